// File: doc/BRIEF.md
# DMA Line-Chunking Request Tracker

This block sits between a DMA requester and a per-line memory controller. The requester hands it byte-granular transfers, each with a start address, a length, a direction and a tag for the host-side buffer. The block splits each transfer into pieces that never cross a line boundary. It passes them one at a time to the line controller and waits for the controller to report each piece finished. When the last piece of a transfer is reported, the block signals completion.

Many transfers may be open at once, up to a configurable cap. Each open transfer is tracked in one record, keyed by the line that holds its first byte. Every new request gets a status in the cycle after it is taken: accepted, refused because the table is full, or refused because its key is already tracked.

For reads, each finished piece comes back with a whole line of data. The block extracts the bytes that belong to the transfer and presents them on a gather port, with the byte position inside the host buffer.

The block is a two-state machine. IDLE takes one event per cycle: a callback if one is valid, otherwise a request. A callback that needs another piece, and an accepted request, both take the transition IDLE→ISSUE. ISSUE holds the piece on the chunk port, and the transition ISSUE→IDLE fires on the chunk handshake. A callback that completes its transfer, a refused request and an unknown callback all stay in IDLE.

Top module: `dmaq_tracker`

## Requirements
- R1: An accepted request returns status 0 on `resp_status` with `resp_valid` one cycle after it is taken. `outstanding` rises by 1 in that same cycle, and `busy` is high exactly while `outstanding` is nonzero.
- R2: A request taken while `outstanding` equals MAX_OUT returns status 1 (full). No record is created and no chunk is issued. The full check takes priority over the alias check.
- R3: A request whose start line key (address bits above the line offset) matches a tracked record returns status 2 (aliased). `outstanding` is unchanged and no chunk is issued.
- R4: The first chunk of an accepted request starts at the start address. Its length is the smaller of the total length and the bytes left in that line.
- R5: After a callback for a record that still has bytes left, exactly one next chunk is issued. It starts at start address plus bytes issued so far, and its length is the smaller of the remaining bytes and a full line.
- R6: On a callback for a read record, the gather port pulses for one cycle with the tag and a position equal to the bytes completed before this piece. Its length equals the piece length. Its data is the returned line shifted down by the start-address offset for the first piece and by 0 for later pieces. A callback for a write record produces no gather pulse.
- R7: When a callback makes bytes completed equal to the total length, `done_valid` pulses with the tag and key. `outstanding` drops by 1 in the same cycle, the record is freed and no chunk is issued.
- R8: A callback whose key matches no record pulses `cb_miss`. It changes neither `outstanding` nor the chunk port.
- R9: While a chunk waits for `chunk_ready`, its address and length hold steady, and both `req_ready` and `cb_ready` are low.
- R10: After reset `outstanding` is 0, `busy` is low, both ready outputs are high, and no valid or pulse output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New transfer request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total length in bytes, nonzero |
| req_write | input | 1 | 1 for write, 0 for read |
| req_tag | input | TAG_W | Host buffer tag |
| resp_valid | output | 1 | Status of the last taken request |
| resp_status | output | 2 | 0 accepted, 1 full, 2 aliased |
| chunk_valid | output | 1 | A piece waits for the line controller |
| chunk_ready | input | 1 | Line controller takes the piece |
| chunk_addr | output | ADDR_W | Byte address of the piece |
| chunk_len | output | CL_W | Bytes in the piece |
| chunk_write | output | 1 | Direction of the piece |
| chunk_key | output | KEY_W | Record key, echoed on the callback |
| chunk_tag | output | TAG_W | Host buffer tag of the piece |
| cb_valid | input | 1 | Line controller reports a piece finished |
| cb_ready | output | 1 | Callback taken this cycle when high with cb_valid |
| cb_key | input | KEY_W | Record key of the finished piece |
| cb_data | input | LINE_BYTES*8 | Line data for reads, byte 0 in the low bits |
| gather_valid | output | 1 | Read bytes ready for the host buffer |
| gather_tag | output | TAG_W | Host buffer tag |
| gather_pos | output | LEN_W | Byte position in the host buffer |
| gather_len | output | CL_W | Valid bytes in gather_data |
| gather_data | output | LINE_BYTES*8 | Bytes to write, first byte in the low bits |
| done_valid | output | 1 | A transfer has finished |
| done_tag | output | TAG_W | Tag of the finished transfer |
| done_key | output | KEY_W | Key of the finished transfer |
| cb_miss | output | 1 | Callback key matched no record |
| busy | output | 1 | Any record open |
| outstanding | output | CNT_W | Number of open records |

## Verification
A corrupted count of bytes issued shows up on the very next chunk as a wrong address or length. It also shows up on the following gather as a wrong position, and it makes completion come early or late. A stale or lost record shows up the next time its key is used. A reused key gets the wrong alias verdict, and a callback to a dropped key raises `cb_miss`. An off-by-one in the open-record count shows up at once on `outstanding` and `busy`, and later as a wrongly timed full status. Each check therefore lands within two cycles of the event that would expose the fault.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    typedef enum logic [1:0] {
        RSP_ACCEPTED = 2'd0,
        RSP_FULL     = 2'd1,
        RSP_ALIASED  = 2'd2
    } dmaq_rsp_e;

    typedef enum logic {
        FSM_IDLE  = 1'b0,
        FSM_ISSUE = 1'b1
    } dmaq_fsm_e;

endpackage

// File: rtl/dmaq_table.sv
module dmaq_table #(
    parameter int DEPTH  = 64,
    parameter int KEY_W  = 26,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int TAG_W  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [IDX_W-1:0]  free_idx,
    output logic [ADDR_W-1:0] h_addr,
    output logic [LEN_W-1:0]  h_len,
    output logic              h_write,
    output logic [TAG_W-1:0]  h_tag,
    output logic [LEN_W-1:0]  h_done,
    output logic [LEN_W-1:0]  h_iss,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              wr_write,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LEN_W-1:0]  wr_done,
    input  logic [LEN_W-1:0]  wr_iss
);

    logic [DEPTH-1:0]  vld;
    logic [KEY_W-1:0]  key_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LEN_W-1:0]  len_q  [DEPTH];
    logic              wr_q   [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LEN_W-1:0]  done_q [DEPTH];
    logic [LEN_W-1:0]  iss_q  [DEPTH];
    logic [DEPTH-1:0]  match;

    // Key compare, one comparator per record
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (key_q[g] == lk_key);
    end

    // Lowest matching record and lowest free record
    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) lk_idx = IDX_W'(i);
            if (!vld[i])  free_idx = IDX_W'(i);
        end
    end

    assign lk_hit  = |match;
    assign h_addr  = addr_q[lk_idx];
    assign h_len   = len_q[lk_idx];
    assign h_write = wr_q[lk_idx];
    assign h_tag   = tag_q[lk_idx];
    assign h_done  = done_q[lk_idx];
    assign h_iss   = iss_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx]  <= wr_key;
            addr_q[wr_idx] <= wr_addr;
            len_q[wr_idx]  <= wr_len;
            wr_q[wr_idx]   <= wr_write;
            tag_q[wr_idx]  <= wr_tag;
            done_q[wr_idx] <= wr_done;
            iss_q[wr_idx]  <= wr_iss;
        end
    end

endmodule

// File: rtl/dmaq_chunk.sv
module dmaq_chunk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    localparam int LB   = $clog2(LINE_BYTES),
    localparam int CL_W = $clog2(LINE_BYTES + 1)
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  total_len,
    input  logic [LEN_W-1:0]  issued,
    output logic [ADDR_W-1:0] c_addr,
    output logic [CL_W-1:0]   c_len,
    output logic [LEN_W-1:0]  iss_next
);

    logic [LB-1:0]    off;
    logic [CL_W-1:0]  room;
    logic [LEN_W-1:0] remain;

    always_comb begin
        c_addr   = base_addr + ADDR_W'(issued);
        off      = c_addr[LB-1:0];
        room     = CL_W'(LINE_BYTES) - CL_W'(off);
        remain   = total_len - issued;
        c_len    = (remain < LEN_W'(room)) ? CL_W'(remain) : room;
        iss_next = issued + LEN_W'(c_len);
    end

endmodule

// File: rtl/dmaq_gather.sv
module dmaq_gather #(
    parameter int LINE_BYTES = 64,
    localparam int LB     = $clog2(LINE_BYTES),
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic [DATA_W-1:0] line_data,
    input  logic              first_piece,
    input  logic [LB-1:0]     start_off,
    output logic [DATA_W-1:0] aligned
);

    logic [LB-1:0] off;

    always_comb begin
        off     = first_piece ? start_off : '0;
        aligned = line_data >> {off, 3'b000};
    end

endmodule

// File: rtl/dmaq_tracker.sv
module dmaq_tracker
    import dmaq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 64,
    parameter int TAG_W      = 8,
    localparam int LB     = $clog2(LINE_BYTES),
    localparam int KEY_W  = ADDR_W - LB,
    localparam int CL_W   = $clog2(LINE_BYTES + 1),
    localparam int CNT_W  = $clog2(MAX_OUT + 1),
    localparam int IDX_W  = $clog2(MAX_OUT),
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic              chunk_valid,
    input  logic              chunk_ready,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [CL_W-1:0]   chunk_len,
    output logic              chunk_write,
    output logic [KEY_W-1:0]  chunk_key,
    output logic [TAG_W-1:0]  chunk_tag,
    input  logic              cb_valid,
    output logic              cb_ready,
    input  logic [KEY_W-1:0]  cb_key,
    input  logic [DATA_W-1:0] cb_data,
    output logic              gather_valid,
    output logic [TAG_W-1:0]  gather_tag,
    output logic [LEN_W-1:0]  gather_pos,
    output logic [CL_W-1:0]   gather_len,
    output logic [DATA_W-1:0] gather_data,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [KEY_W-1:0]  done_key,
    output logic              cb_miss,
    output logic              busy,
    output logic [CNT_W-1:0]  outstanding
);

    dmaq_fsm_e state, state_nx;

    logic              take_cb, take_req, is_full;
    logic              acc_req, cb_hit, cb_fin, cb_more, load_chunk;
    logic [KEY_W-1:0]  lk_key;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx, free_idx;
    logic [ADDR_W-1:0] h_addr;
    logic [LEN_W-1:0]  h_len, h_done, h_iss;
    logic              h_write;
    logic [TAG_W-1:0]  h_tag;
    logic [ADDR_W-1:0] src_addr, c_addr;
    logic [LEN_W-1:0]  src_len, src_iss, iss_next;
    logic [CL_W-1:0]   c_len;
    logic [DATA_W-1:0] aligned;
    dmaq_rsp_e         rsp_nx;

    // ---------------- decision logic ----------------
    always_comb begin
        cb_ready  = (state == FSM_IDLE);
        req_ready = (state == FSM_IDLE) && !cb_valid;
        take_cb   = cb_valid && cb_ready;
        take_req  = req_valid && req_ready;
        lk_key    = cb_valid ? cb_key : req_addr[ADDR_W-1:LB];
        is_full   = (outstanding == CNT_W'(MAX_OUT));
        acc_req   = take_req && !is_full && !lk_hit;
        cb_hit    = take_cb && lk_hit;
        cb_fin    = cb_hit && (h_iss == h_len);
        cb_more   = cb_hit && !cb_fin;
        load_chunk = acc_req || cb_more;

        src_addr  = take_cb ? h_addr : req_addr;
        src_len   = take_cb ? h_len : req_len;
        src_iss   = take_cb ? h_iss : '0;

        if (is_full)     rsp_nx = RSP_FULL;
        else if (lk_hit) rsp_nx = RSP_ALIASED;
        else             rsp_nx = RSP_ACCEPTED;

        state_nx = state;
        unique case (state)
            FSM_IDLE:  if (load_chunk)  state_nx = FSM_ISSUE;
            FSM_ISSUE: if (chunk_ready) state_nx = FSM_IDLE;
            default:   state_nx = FSM_IDLE;
        endcase
    end

    // ---------------- sub-blocks ----------------
    dmaq_table #(
        .DEPTH(MAX_OUT), .KEY_W(KEY_W), .ADDR_W(ADDR_W),
        .LEN_W(LEN_W), .TAG_W(TAG_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_key(lk_key), .lk_hit(lk_hit), .lk_idx(lk_idx), .free_idx(free_idx),
        .h_addr(h_addr), .h_len(h_len), .h_write(h_write), .h_tag(h_tag),
        .h_done(h_done), .h_iss(h_iss),
        .wr_en(acc_req || cb_hit),
        .wr_idx(acc_req ? free_idx : lk_idx),
        .wr_valid(!cb_fin),
        .wr_key(lk_key),
        .wr_addr(src_addr),
        .wr_len(src_len),
        .wr_write(take_cb ? h_write : req_write),
        .wr_tag(take_cb ? h_tag : req_tag),
        .wr_done(src_iss),
        .wr_iss(iss_next)
    );

    dmaq_chunk #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
    ) u_chunk (
        .base_addr(src_addr), .total_len(src_len), .issued(src_iss),
        .c_addr(c_addr), .c_len(c_len), .iss_next(iss_next)
    );

    dmaq_gather #(
        .LINE_BYTES(LINE_BYTES)
    ) u_gather (
        .line_data(cb_data),
        .first_piece(h_done == '0),
        .start_off(h_addr[LB-1:0]),
        .aligned(aligned)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FSM_IDLE;
        else        state <= state_nx;
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding  <= '0;
            chunk_valid  <= 1'b0;
            chunk_addr   <= '0;
            chunk_len    <= '0;
            chunk_write  <= 1'b0;
            chunk_key    <= '0;
            chunk_tag    <= '0;
            resp_valid   <= 1'b0;
            resp_status  <= RSP_ACCEPTED;
            gather_valid <= 1'b0;
            gather_tag   <= '0;
            gather_pos   <= '0;
            gather_len   <= '0;
            gather_data  <= '0;
            done_valid   <= 1'b0;
            done_tag     <= '0;
            done_key     <= '0;
            cb_miss      <= 1'b0;
        end else begin
            if (acc_req)     outstanding <= outstanding + 1'b1;
            else if (cb_fin) outstanding <= outstanding - 1'b1;

            if (load_chunk) begin
                chunk_valid <= 1'b1;
                chunk_addr  <= c_addr;
                chunk_len   <= c_len;
                chunk_write <= take_cb ? h_write : req_write;
                chunk_key   <= lk_key;
                chunk_tag   <= take_cb ? h_tag : req_tag;
            end else if (chunk_valid && chunk_ready) begin
                chunk_valid <= 1'b0;
            end

            resp_valid  <= take_req;
            resp_status <= rsp_nx;

            gather_valid <= cb_hit && !h_write;
            gather_tag   <= h_tag;
            gather_pos   <= h_done;
            gather_len   <= CL_W'(h_iss - h_done);
            gather_data  <= aligned;

            done_valid <= cb_fin;
            done_tag   <= h_tag;
            done_key   <= lk_key;

            cb_miss <= take_cb && !lk_hit;
        end
    end

    assign busy = (outstanding != '0);

endmodule

// File: rtl/dmaq_tracker_chk.sv
module dmaq_tracker_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 64,
    parameter int CL_W       = 7,
    parameter int CNT_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cb_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_status,
    input logic              chunk_valid,
    input logic              chunk_ready,
    input logic [ADDR_W-1:0] chunk_addr,
    input logic [CL_W-1:0]   chunk_len,
    input logic              done_valid,
    input logic              cb_miss,
    input logic [CNT_W-1:0]  outstanding
);

    localparam int LB = $clog2(LINE_BYTES);

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT); // R2

    AST_FULL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd1) |-> int'(outstanding) == MAX_OUT); // R2

    AST_ACCEPT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd0) |-> outstanding == CNT_W'($past(outstanding) + 1'b1)); // R1

    AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status != 2'd0) |-> $stable(outstanding)); // R3

    AST_DONE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> outstanding == CNT_W'($past(outstanding) - 1'b1)); // R7

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cb_miss |-> ($stable(outstanding) && !chunk_valid)); // R8

    AST_CHUNK_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (chunk_len != '0 &&
                         int'(chunk_addr[LB-1:0]) + int'(chunk_len) <= LINE_BYTES)); // R4

    AST_CHUNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_addr) && $stable(chunk_len))); // R9

    AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (!req_ready && !cb_ready)); // R9

endmodule

bind dmaq_tracker dmaq_tracker_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT),
    .CL_W(CL_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_ready(req_ready), .cb_ready(cb_ready),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len),
    .done_valid(done_valid), .cb_miss(cb_miss),
    .outstanding(outstanding)
);

// File: tb/dmaq_tracker_tb.sv
module dmaq_tracker_tb;

    localparam int AW = 16, LW = 8, LBY = 16, MO = 4, TW = 4;
    localparam int KW = AW - 4, CLW = 5, CW = 3, DW = LBY * 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, chunk_ready = 1, cb_valid = 0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [TW-1:0] req_tag = '0;
    logic [KW-1:0] cb_key = '0;
    logic [DW-1:0] cb_data = '0;
    logic req_ready, resp_valid, chunk_valid, chunk_write, cb_ready;
    logic gather_valid, done_valid, cb_miss, busy;
    logic [1:0] resp_status;
    logic [AW-1:0] chunk_addr;
    logic [CLW-1:0] chunk_len, gather_len;
    logic [KW-1:0] chunk_key, done_key;
    logic [TW-1:0] chunk_tag, gather_tag, done_tag;
    logic [LW-1:0] gather_pos;
    logic [DW-1:0] gather_data;
    logic [CW-1:0] outstanding;

    always #4 clk = ~clk;

    dmaq_tracker #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LBY), .MAX_OUT(MO), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_tag(req_tag),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready), .chunk_addr(chunk_addr),
        .chunk_len(chunk_len), .chunk_write(chunk_write), .chunk_key(chunk_key),
        .chunk_tag(chunk_tag),
        .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_key(cb_key), .cb_data(cb_data),
        .gather_valid(gather_valid), .gather_tag(gather_tag), .gather_pos(gather_pos),
        .gather_len(gather_len), .gather_data(gather_data),
        .done_valid(done_valid), .done_tag(done_tag), .done_key(done_key),
        .cb_miss(cb_miss), .busy(busy), .outstanding(outstanding)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench-side record model
    bit s_used [MO];
    int s_addr [MO], s_len [MO], s_tag [MO], s_done [MO], s_iss [MO];
    bit s_wr [MO];
    int cnt_exp = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ceq(input string req, input longint act, input longint exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic int f_clen(input int a, input int l, input int iss);
        int room, rem;
        room = LBY - ((a + iss) % LBY);
        rem  = l - iss;
        return (rem < room) ? rem : room;
    endfunction

    function automatic int f_find_key(input int key);
        for (int i = 0; i < MO; i++)
            if (s_used[i] && (s_addr[i] / LBY) == key) return i;
        return -1;
    endfunction

    function automatic int f_free();
        for (int i = 0; i < MO; i++) if (!s_used[i]) return i;
        return -1;
    endfunction

    task automatic do_req(input int a, input int l, input bit w, input int t);
        int exp_st, s, cl;
        if (cnt_exp == MO)               exp_st = 1;
        else if (f_find_key(a / LBY) >= 0) exp_st = 2;
        else                             exp_st = 0;
        @(negedge clk);
        req_valid = 1; req_addr = AW'(a); req_len = LW'(l); req_write = w; req_tag = TW'(t);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        ceq("R1 resp_valid", resp_valid, 1);
        if (exp_st == 1) ceq("R2 status", resp_status, 1);
        else if (exp_st == 2) ceq("R3 status", resp_status, 2);
        else ceq("R1 status", resp_status, 0);
        if (exp_st == 0) begin
            s = f_free();
            cl = f_clen(a, l, 0);
            s_used[s] = 1; s_addr[s] = a; s_len[s] = l; s_wr[s] = w; s_tag[s] = t;
            s_done[s] = 0; s_iss[s] = cl;
            cnt_exp++;
            ceq("R1 outstanding", outstanding, cnt_exp);
            ceq("R1 busy", busy, 1);
            ceq("R4 chunk_valid", chunk_valid, 1);
            ceq("R4 chunk_addr", chunk_addr, a);
            ceq("R4 chunk_len", chunk_len, cl);
            ceq("R4 chunk_key", chunk_key, a / LBY);
        end else begin
            ceq(exp_st == 1 ? "R2 outstanding" : "R3 outstanding", outstanding, cnt_exp);
            ceq(exp_st == 1 ? "R2 no chunk" : "R3 no chunk", chunk_valid, 0);
        end
    endtask

    task automatic do_cb(input int s);
        logic [DW-1:0] d, msk, expd;
        int off, plen, cl;
        d = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        cb_valid = 1; cb_key = KW'(s_addr[s] / LBY); cb_data = d;
        @(posedge clk);
        @(negedge clk);
        cb_valid = 0;
        plen = s_iss[s] - s_done[s];
        if (!s_wr[s]) begin
            off  = (s_done[s] == 0) ? (s_addr[s] % LBY) : 0;
            msk  = (DW'(1) << (plen * 8)) - 1'b1;
            expd = (d >> (off * 8)) & msk;
            ceq("R6 gather_valid", gather_valid, 1);
            ceq("R6 gather_pos", gather_pos, s_done[s]);
            ceq("R6 gather_len", gather_len, plen);
            ceq("R6 gather_tag", gather_tag, s_tag[s]);
            check((gather_data & msk) == expd, "R6 gather_data", longint'(gather_data[63:0]), longint'(expd[63:0]));
        end else begin
            ceq("R6 no gather on write", gather_valid, 0);
        end
        s_done[s] = s_iss[s];
        if (s_done[s] == s_len[s]) begin
            cnt_exp--;
            s_used[s] = 0;
            ceq("R7 done_valid", done_valid, 1);
            ceq("R7 done_tag", done_tag, s_tag[s]);
            ceq("R7 done_key", done_key, s_addr[s] / LBY);
            ceq("R7 outstanding", outstanding, cnt_exp);
            ceq("R7 no chunk", chunk_valid, 0);
        end else begin
            cl = f_clen(s_addr[s], s_len[s], s_iss[s]);
            ceq("R5 done_valid", done_valid, 0);
            ceq("R5 chunk_valid", chunk_valid, 1);
            ceq("R5 chunk_addr", chunk_addr, s_addr[s] + s_iss[s]);
            ceq("R5 chunk_len", chunk_len, cl);
            s_iss[s] += cl;
        end
        ceq("R1 busy", busy, cnt_exp != 0);
    endtask

    task automatic do_miss(input int key);
        @(negedge clk);
        cb_valid = 1; cb_key = KW'(key); cb_data = '0;
        @(posedge clk);
        @(negedge clk);
        cb_valid = 0;
        ceq("R8 cb_miss", cb_miss, 1);
        ceq("R8 outstanding", outstanding, cnt_exp);
        ceq("R8 no chunk", chunk_valid, 0);
        ceq("R8 no done", done_valid, 0);
    endtask

    function automatic int pick_used();
        int k = $urandom % MO;
        for (int i = 0; i < MO; i++) if (s_used[(k + i) % MO]) return (k + i) % MO;
        return -1;
    endfunction

    task automatic drain();
        int s;
        s = pick_used();
        while (s >= 0) begin
            do_cb(s);
            s = pick_used();
        end
    endtask

    initial begin
        logic [AW-1:0] held_addr;
        void'($urandom(32'd4242));
        for (int i = 0; i < MO; i++) s_used[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        ceq("R10 outstanding", outstanding, 0);
        ceq("R10 busy", busy, 0);
        ceq("R10 req_ready", req_ready, 1);
        ceq("R10 cb_ready", cb_ready, 1);
        ceq("R10 chunk_valid", chunk_valid, 0);
        ceq("R10 resp_valid", resp_valid, 0);
        ceq("R10 done_valid", done_valid, 0);

        // directed: single-line read, unaligned multi-line read, write
        do_req(16'h0103, 5, 0, 1);
        do_req(16'h020D, 37, 0, 2);
        do_req(16'h0300, 16, 1, 3);
        // alias on a tracked line (different offset)
        do_req(16'h0209, 4, 0, 4);
        // fill to cap, then full
        do_req(16'h0400, 1, 0, 5);
        do_req(16'h0500, 3, 1, 6);
        do_miss(12'h0FF);
        drain();

        // backpressure on the chunk port
        chunk_ready = 0;
        do_req(16'h0608, 20, 0, 7);
        held_addr = chunk_addr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ceq("R9 chunk held", chunk_valid, 1);
            ceq("R9 addr stable", chunk_addr, held_addr);
            ceq("R9 req_ready low", req_ready, 0);
            ceq("R9 cb_ready low", cb_ready, 0);
        end
        chunk_ready = 1;
        @(posedge clk);
        @(negedge clk);
        ceq("R9 released", chunk_valid, 0);
        drain();

        // constrained random mix
        for (int it = 0; it < 1500; it++) begin
            int op, s;
            op = $urandom % 10;
            s = pick_used();
            if (op == 0) begin
                do_miss(12'h0F0 + ($urandom % 8));
            end else if (s < 0 || op < 5) begin
                do_req(16'h0100 + ($urandom % 8) * LBY + ($urandom % LBY),
                       1 + ($urandom % 40), 1'($urandom), $urandom % 16);
            end else begin
                do_cb(s);
            end
        end
        drain();
        @(negedge clk);
        ceq("R1 idle at end", busy, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule